// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block is the decision core of an eight-line interrupt controller. It keeps three registers: pending requests, a mask, and the lines now in service. From these it decides whether the processor should be interrupted and which line should be reported. A per-line trigger register makes each input either edge sensitive or level sensitive. A rotation register moves the highest-priority position around the ring of lines, so equal-class sources can share service fairly.

Surrounding logic drives the block. That logic writes the mask and trigger registers, answers `irq_out` with an acknowledge strobe, and later closes each service with an end-of-interrupt command. The command is either non-specific (close the most urgent in-service line) or specific (close a named line), and either form can also rotate priority. Three static configuration pins select these options:
- automatic end of service at acknowledge time, with optional rotation;
- a nesting mode that leaves the cascade line (line 2) out of the in-service comparison.

`irq_out` and `ack_line` are combinational from the registers. Every register update takes effect at the next rising clock edge.

Top module: `irq_prio_core`

## Requirements
- R1: A synchronous active-low reset clears the request, mask, trigger, in-service and rotation registers. After reset `irq_out` is 0, `ack_line` reads 7, and line 0 has the highest priority.
- R2: A line whose trigger bit is 0 (edge) sets its request bit when the input is high in this cycle and was low in the previous one. The bit stays set after the input falls, and an acknowledge of that line clears it. A held-high input does not set it again.
- R3: A line whose trigger bit is 1 (level) has a request bit equal to the input one cycle earlier. An acknowledge does not clear it.
- R4: A line whose mask bit is 1 takes no part in the pending search. Clearing the mask bit lets a stored request through.
- R5: Among the pending unmasked lines, the winner is the line with the smallest value of (line − rotation) mod 8. `ack_line` gives that line while `irq_out` is 1.
- R6: `irq_out` is 1 only when the winner's rotated position is strictly smaller than that of the most urgent in-service line. A request at the same or lower priority as a line in service is held off.
- R7: With `cfg_nest_excl` = 1, in-service line 2 is ignored when finding the most urgent in-service line, so line 2 can interrupt itself.
- R8: `inta` while `irq_out` = 1 sets the in-service bit of `ack_line`, unless automatic end of service is on. `inta` while `irq_out` = 0 changes no state, and `ack_line` reads 7.
- R9: With `cfg_auto_eoi` = 1, an acknowledge sets no in-service bit. If `cfg_rot_aeoi` is also 1, the rotation becomes (acknowledged line + 1) mod 8.
- R10: `eoi_ns` clears the most urgent in-service bit, searching all in-service lines in rotated order. With `eoi_rot` = 1 the rotation becomes (that line + 1) mod 8. With nothing in service, no state changes.
- R11: `eoi_sp` clears the in-service bit of `eoi_line` (3 bits). With `eoi_rot` = 1 the rotation becomes (`eoi_line` + 1) mod 8.
- R12: An acknowledge and an end-of-interrupt in the same cycle both take effect. The clear is applied to the in-service register as it was before the acknowledge, and the acknowledge's set wins on a shared line. A rotation caused by an end-of-interrupt wins over one caused by an automatic end of service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_in | input | 8 | Interrupt request inputs, one per line |
| mask_we | input | 1 | Write strobe for the mask register |
| mask_wdata | input | 8 | New mask value; bit 1 blocks the line |
| trig_we | input | 1 | Write strobe for the trigger register |
| trig_wdata | input | 8 | New trigger value; bit 1 = level, 0 = edge |
| cfg_auto_eoi | input | 1 | Acknowledge does not set in-service |
| cfg_rot_aeoi | input | 1 | Rotate on automatic end of service |
| cfg_nest_excl | input | 1 | Ignore in-service line 2 in the nesting check |
| inta | input | 1 | Acknowledge strobe, one cycle |
| eoi_ns | input | 1 | Non-specific end of interrupt |
| eoi_sp | input | 1 | Specific end of interrupt |
| eoi_rot | input | 1 | End of interrupt also rotates priority |
| eoi_line | input | 3 | Line closed by a specific end of interrupt |
| irq_out | output | 1 | Interrupt request to the processor |
| ack_line | output | 3 | Line selected for acknowledge (7 when none) |

## Verification
The acknowledge and an end-of-interrupt can arrive in the same clock cycle. In that case the in-service register is cleared and set at once, and the rotation register can be asked for two different values. The bench builds this case with line 5 in service and line 2 pending. It asserts `inta` and `eoi_ns` together, then shows through later requests that line 5 has left service and line 2 has entered it. Directed sequences check the rotation outcomes at the ports by the line that wins afterwards.

// File: rtl/irq_prio_pkg.sv
// Package irq_prio_pkg
// Shared constants of the rotating priority interrupt resolver.
// Assumes the line count is a power of two, so rotated indices wrap by
// plain truncation.
package irq_prio_pkg;
    parameter int unsigned LINES_DEF   = 8;
    parameter int unsigned CASCADE_DEF = 2;
endpackage

// File: rtl/irq_prio_find.sv
// Module irq_prio_find
// Combinational rotated priority search. It returns the smallest position p
// such that vec[(p + rot) mod N] is set, or N when vec is empty.
// Assumes N is a power of two.
module irq_prio_find #(
    parameter int unsigned N  = 8,
    localparam int unsigned LW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    input  logic [LW-1:0] rot,
    output logic [LW:0]   pos
);
    // Scan from the lowest priority up, so the most urgent hit is written last.
    always_comb begin
        pos = (LW+1)'(N);
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[LW'(i) + rot]) begin
                pos = (LW+1)'(i);
            end
        end
    end
endmodule

// File: rtl/irq_req_stage.sv
// Module irq_req_stage
// Request register with per-line edge or level capture. An edge line
// latches a low-to-high change until it is acknowledged. A level line
// copies its input each cycle. Assumes ack_clr is one-hot or zero.
module irq_req_stage #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_in,
    input  logic [N-1:0] trig_q,
    input  logic [N-1:0] ack_clr,
    output logic [N-1:0] req_q
);
    logic [N-1:0] last_q;
    logic [N-1:0] req_d;

    // Next request value per line; a new edge wins over an acknowledge clear.
    for (genvar g = 0; g < N; g++) begin : g_line
        always_comb begin
            if (trig_q[g]) begin
                req_d[g] = req_in[g];
            end else begin
                req_d[g] = (req_q[g] & ~ack_clr[g]) | (req_in[g] & ~last_q[g]);
            end
        end

        // R2: an edge line latches a fresh rising input.
        assert_edge_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!trig_q[g] && req_in[g] && !last_q[g]) |=> req_q[g]);

        // R3: a level line tracks its input one cycle late.
        assert_level_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
            trig_q[g] |=> (req_q[g] == $past(req_in[g])));
    end

    // Store the previous input levels and the request register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= '0;
            req_q  <= '0;
        end else begin
            last_q <= req_in;
            req_q  <= req_d;
        end
    end
endmodule

// File: rtl/irq_service_ctl.sv
// Module irq_service_ctl
// Holds the in-service register and the rotation register, and applies
// acknowledge, non-specific and specific end-of-interrupt in one cycle.
// Assumes eoi_pos is the rotated search result over the full in-service set.
module irq_service_ctl #(
    parameter int unsigned N  = 8,
    localparam int unsigned LW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ack_fire,
    input  logic [LW-1:0] ack_idx,
    input  logic          cfg_auto_eoi,
    input  logic          cfg_rot_aeoi,
    input  logic          eoi_ns,
    input  logic          eoi_sp,
    input  logic          eoi_rot,
    input  logic [LW-1:0] eoi_line,
    input  logic [LW:0]   eoi_pos,
    output logic [N-1:0]  isr_q,
    output logic [LW-1:0] rot_q
);
    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    logic          ns_hit;
    logic [LW-1:0] ns_idx;
    logic [N-1:0]  clr_vec;
    logic [N-1:0]  set_vec;
    logic [N-1:0]  isr_d;
    logic [LW-1:0] rot_d;

    // Pick the line closed by a non-specific command and build the masks.
    always_comb begin
        ns_hit  = eoi_ns && !eoi_pos[LW];
        ns_idx  = eoi_pos[LW-1:0] + rot_q;
        clr_vec = '0;
        if (ns_hit) clr_vec = clr_vec | (ONE << ns_idx);
        if (eoi_sp) clr_vec = clr_vec | (ONE << eoi_line);
        set_vec = (ack_fire && !cfg_auto_eoi) ? (ONE << ack_idx) : '0;
        isr_d   = (isr_q & ~clr_vec) | set_vec;
    end

    // Choose the next rotation; end-of-interrupt forms win over auto rotation.
    always_comb begin
        rot_d = rot_q;
        if (eoi_sp && eoi_rot) begin
            rot_d = eoi_line + LW'(1);
        end else if (ns_hit && eoi_rot) begin
            rot_d = ns_idx + LW'(1);
        end else if (ack_fire && cfg_auto_eoi && cfg_rot_aeoi) begin
            rot_d = ack_idx + LW'(1);
        end
    end

    // Register the in-service set and the rotation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= '0;
            rot_q <= '0;
        end else begin
            isr_q <= isr_d;
            rot_q <= rot_d;
        end
    end

    // R11: rotating specific end of interrupt moves priority past the named line.
    assert_seoi_rot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_sp && eoi_rot) |=> (rot_q == $past(eoi_line) + LW'(1)));

    // R11: a specific end of interrupt without an acknowledge empties that line.
    assert_seoi_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_sp && !ack_fire) |=> !isr_q[$past(eoi_line)]);
endmodule

// File: rtl/irq_prio_core.sv
// Module irq_prio_core
// Top of the rotating priority interrupt resolver. Holds the mask and
// trigger registers, runs three rotated searches (pending, nesting view,
// full in-service) and drives irq_out and ack_line. Assumes the command
// strobes are single-cycle pulses from a surrounding decoder.
module irq_prio_core #(
    parameter int unsigned NUM_LINES    = irq_prio_pkg::LINES_DEF,
    parameter int unsigned CASCADE_LINE = irq_prio_pkg::CASCADE_DEF,
    localparam int unsigned LW = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] req_in,
    input  logic                 mask_we,
    input  logic [NUM_LINES-1:0] mask_wdata,
    input  logic                 trig_we,
    input  logic [NUM_LINES-1:0] trig_wdata,
    input  logic                 cfg_auto_eoi,
    input  logic                 cfg_rot_aeoi,
    input  logic                 cfg_nest_excl,
    input  logic                 inta,
    input  logic                 eoi_ns,
    input  logic                 eoi_sp,
    input  logic                 eoi_rot,
    input  logic [LW-1:0]        eoi_line,
    output logic                 irq_out,
    output logic [LW-1:0]        ack_line
);
    localparam logic [NUM_LINES-1:0] ONE  = {{(NUM_LINES-1){1'b0}}, 1'b1};
    localparam logic [NUM_LINES-1:0] EXCL = ONE << CASCADE_LINE;

    logic [NUM_LINES-1:0] imr_q;
    logic [NUM_LINES-1:0] trig_q;
    logic [NUM_LINES-1:0] req_q;
    logic [NUM_LINES-1:0] isr_q;
    logic [LW-1:0]        rot_q;
    logic [NUM_LINES-1:0] pend_vec;
    logic [NUM_LINES-1:0] isr_view;
    logic [LW:0]          pend_pos;
    logic [LW:0]          cur_pos;
    logic [LW:0]          full_pos;
    logic [LW-1:0]        win_idx;
    logic                 ack_fire;
    logic [NUM_LINES-1:0] ack_clr;

    // Hold the software-written mask and trigger registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imr_q  <= '0;
            trig_q <= '0;
        end else begin
            if (mask_we) imr_q  <= mask_wdata;
            if (trig_we) trig_q <= trig_wdata;
        end
    end

    // Form the search inputs and the acknowledge controls.
    always_comb begin
        pend_vec = req_q & ~imr_q;
        isr_view = cfg_nest_excl ? (isr_q & ~EXCL) : isr_q;
        win_idx  = pend_pos[LW-1:0] + rot_q;
        irq_out  = pend_pos < cur_pos;
        ack_line = irq_out ? win_idx : '1;
        ack_fire = inta && irq_out;
        ack_clr  = ack_fire ? (ONE << win_idx) : '0;
    end

    irq_req_stage #(.N(NUM_LINES)) req_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_in  (req_in),
        .trig_q  (trig_q),
        .ack_clr (ack_clr),
        .req_q   (req_q)
    );

    irq_prio_find #(.N(NUM_LINES)) find_pend_i (
        .vec (pend_vec),
        .rot (rot_q),
        .pos (pend_pos)
    );

    irq_prio_find #(.N(NUM_LINES)) find_cur_i (
        .vec (isr_view),
        .rot (rot_q),
        .pos (cur_pos)
    );

    irq_prio_find #(.N(NUM_LINES)) find_full_i (
        .vec (isr_q),
        .rot (rot_q),
        .pos (full_pos)
    );

    irq_service_ctl #(.N(NUM_LINES)) svc_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ack_fire     (ack_fire),
        .ack_idx      (win_idx),
        .cfg_auto_eoi (cfg_auto_eoi),
        .cfg_rot_aeoi (cfg_rot_aeoi),
        .eoi_ns       (eoi_ns),
        .eoi_sp       (eoi_sp),
        .eoi_rot      (eoi_rot),
        .eoi_line     (eoi_line),
        .eoi_pos      (full_pos),
        .isr_q        (isr_q),
        .rot_q        (rot_q)
    );

    // R4: the reported line is never a masked one.
    assert_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> !imr_q[ack_line]);

    // R8: a real acknowledge puts the line in service.
    assert_ack_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && !cfg_auto_eoi) |=> isr_q[$past(ack_line)]);

    // R8: an acknowledge with nothing to report leaves service state alone.
    assert_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && !irq_out && !eoi_ns && !eoi_sp) |=> ($stable(isr_q) && $stable(rot_q)));

    // R9: automatic end of service never adds an in-service bit.
    assert_aeoi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && cfg_auto_eoi && !eoi_ns && !eoi_sp) |=> $stable(isr_q));
endmodule

// File: tb/irq_prio_core_tb.sv
`timescale 1ns/1ps
module irq_prio_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] req_in;
    logic       mask_we;
    logic [7:0] mask_wdata;
    logic       trig_we;
    logic [7:0] trig_wdata;
    logic       cfg_auto_eoi, cfg_rot_aeoi, cfg_nest_excl;
    logic       inta, eoi_ns, eoi_sp, eoi_rot;
    logic [2:0] eoi_line;
    logic       irq_out;
    logic [2:0] ack_line;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    irq_prio_core dut_i (
        .clk(clk), .rst_n(rst_n), .req_in(req_in),
        .mask_we(mask_we), .mask_wdata(mask_wdata),
        .trig_we(trig_we), .trig_wdata(trig_wdata),
        .cfg_auto_eoi(cfg_auto_eoi), .cfg_rot_aeoi(cfg_rot_aeoi),
        .cfg_nest_excl(cfg_nest_excl), .inta(inta),
        .eoi_ns(eoi_ns), .eoi_sp(eoi_sp), .eoi_rot(eoi_rot),
        .eoi_line(eoi_line), .irq_out(irq_out), .ack_line(ack_line)
    );

    // Vector layout: {req[22:15], mask[14:7], rot[6:4], irq[3], line[2:0]}
    localparam logic [22:0] VEC [10] = '{
        {8'h00, 8'h00, 3'd0, 1'b0, 3'd0},
        {8'h01, 8'h00, 3'd0, 1'b1, 3'd0},
        {8'h88, 8'h00, 3'd0, 1'b1, 3'd3},
        {8'h88, 8'h00, 3'd4, 1'b1, 3'd7},
        {8'h0A, 8'h02, 3'd0, 1'b1, 3'd3},
        {8'hFF, 8'hFF, 3'd0, 1'b0, 3'd0},
        {8'h41, 8'h00, 3'd7, 1'b1, 3'd0},
        {8'h41, 8'h00, 3'd1, 1'b1, 3'd6},
        {8'h30, 8'h10, 3'd6, 1'b1, 3'd5},
        {8'h80, 8'h00, 3'd0, 1'b1, 3'd7}
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_in = '0; mask_we = 0; mask_wdata = '0;
        trig_we = 0; trig_wdata = '0; cfg_auto_eoi = 0; cfg_rot_aeoi = 0;
        cfg_nest_excl = 0; inta = 0; eoi_ns = 0; eoi_sp = 0; eoi_rot = 0;
        eoi_line = '0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic raise(input int ln);
        req_in[ln] = 1'b1; step();
    endtask

    task automatic drop(input int ln);
        req_in[ln] = 1'b0; step();
    endtask

    task automatic ack();
        inta = 1'b1; step(); inta = 1'b0;
    endtask

    task automatic ns_eoi(input bit rot);
        eoi_ns = 1'b1; eoi_rot = rot; step(); eoi_ns = 1'b0; eoi_rot = 1'b0;
    endtask

    task automatic sp_eoi(input int ln, input bit rot);
        eoi_sp = 1'b1; eoi_rot = rot; eoi_line = 3'(ln); step();
        eoi_sp = 1'b0; eoi_rot = 1'b0;
    endtask

    task automatic serve(input int ln);
        raise(ln); ack(); drop(ln);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state and default rotation.
        do_reset();
        chk("R1 irq after reset", irq_out, 0);
        chk("R1 ack_line idle", ack_line, 7);
        req_in = 8'h81; step();
        chk("R1 rotation zero", ack_line, 0);

        // R5 and R4: table of patterns, masks and rotations.
        for (int k = 0; k < 10; k++) begin
            logic [22:0] v;
            v = VEC[k];
            do_reset();
            mask_we = 1; mask_wdata = v[14:7]; step(); mask_we = 0;
            if (v[6:4] != 3'd0) sp_eoi(int'(v[6:4] - 3'd1), 1'b1);
            req_in = v[22:15]; step();
            chk($sformatf("R5 vec%0d irq", k), irq_out, v[3]);
            if (v[3]) chk($sformatf("R5 R11 vec%0d line", k), ack_line, v[2:0]);
        end

        // R4: a stored request waits behind its mask bit.
        do_reset();
        mask_we = 1; mask_wdata = 8'h20; step(); mask_we = 0;
        raise(5);
        chk("R4 masked", irq_out, 0);
        mask_we = 1; mask_wdata = 8'h00; step(); mask_we = 0;
        chk("R4 unmasked", ack_line, 5);

        // R2: edge capture, latch after fall, clear on acknowledge.
        do_reset();
        cfg_auto_eoi = 1;
        raise(5);
        chk("R2 edge set", ack_line, 5);
        drop(5);
        chk("R2 latched", irq_out, 1);
        raise(5); drop(5);
        ack(); step();
        chk("R2 cleared by ack", irq_out, 0);
        raise(5); ack(); step();
        chk("R2 held high no reset", irq_out, 0);

        // R3: level line survives acknowledge and follows a drop.
        do_reset();
        cfg_auto_eoi = 1;
        trig_we = 1; trig_wdata = 8'h08; step(); trig_we = 0;
        raise(3); ack();
        chk("R3 still pending", ack_line, 3);
        drop(3);
        chk("R3 follows drop", irq_out, 0);

        // R6: nesting against a line in service.
        do_reset();
        serve(5);
        raise(6);
        chk("R6 lower held off", irq_out, 0);
        raise(2);
        chk("R6 higher passes", ack_line, 2);
        do_reset();
        serve(5); raise(5);
        chk("R6 equal held off", irq_out, 0);

        // R7: cascade line exclusion.
        do_reset();
        cfg_nest_excl = 1;
        serve(2); raise(2);
        chk("R7 line2 re-enters", ack_line, 2);
        do_reset();
        serve(2); raise(2);
        chk("R7 off blocks line2", irq_out, 0);

        // R8: spurious acknowledge changes nothing.
        do_reset();
        chk("R8 spurious line", ack_line, 7);
        ack();
        raise(1);
        chk("R8 no state change", ack_line, 1);

        // R10: non-specific end of interrupt.
        do_reset();
        serve(5); serve(2); raise(3);
        chk("R10 blocked by 2", irq_out, 0);
        ns_eoi(1'b0);
        chk("R10 cleared 2", ack_line, 3);
        do_reset();
        serve(5); ns_eoi(1'b1);
        req_in = 8'h81; step();
        chk("R10 rotate to 6", ack_line, 7);
        do_reset();
        ns_eoi(1'b1);
        req_in = 8'h81; step();
        chk("R10 empty no rotate", ack_line, 0);

        // R11: specific end of interrupt.
        do_reset();
        serve(5); serve(2); raise(3);
        sp_eoi(5, 1'b0);
        chk("R11 2 still in service", irq_out, 0);
        sp_eoi(2, 1'b0);
        chk("R11 2 cleared", ack_line, 3);

        // R9: automatic end of service, with and without rotation.
        do_reset();
        cfg_auto_eoi = 1; cfg_rot_aeoi = 1;
        serve(4);
        req_in = 8'h11; step();
        chk("R9 rotate past 4", ack_line, 0);
        do_reset();
        cfg_auto_eoi = 1;
        serve(4); raise(6);
        chk("R9 no in-service set", ack_line, 6);

        // R12: acknowledge and end of interrupt in one cycle.
        do_reset();
        serve(5); raise(2);
        chk("R12 line2 offered", ack_line, 2);
        inta = 1; eoi_ns = 1; step(); inta = 0; eoi_ns = 0;
        drop(2); raise(6);
        chk("R12 line2 in service", irq_out, 0);
        sp_eoi(2, 1'b0);
        chk("R12 line5 was closed", ack_line, 6);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule